// File: doc/BRIEF.md
# Masked Bitfield Register Bus

A word-addressed register block in which one address can host several independent registers, each owning the bits of that word named by its own field mask. A bus access carries a per-bit access mask. A write touches only the fields it overlaps, and inside each of them only the bits that both the access mask and the field mask select. A read assembles the word by ORing the contributions of every readable field at the address, each limited to its field mask and to the access mask.

Every field has one of four kinds, fixed at elaboration together with its word address, mask and reset value: read-write, read-only (bus writes are accepted but ignored, and the value is loaded from inside the chip through a load port), fixed constant (reserved bits or identification values), and write-only. Readable and writable address sets are tracked separately, so an address that holds only write-only fields answers reads with the unmapped status. Each field also drives a right-aligned copy of its value for the logic around the block. Responses are combinational: status and read data belong to the cycle in which the request is presented.

Top module: `mbf_regbus`

## Requirements
- R1: After reset every field holds its parameter reset value limited to its mask, visible both on bus reads and on the field value outputs.
- R2: A bus write to a read-write or write-only field sets its value to (value & ~m) | (wdata & m), with m = access mask & field mask; registered at the clock edge that ends the access cycle, and a field not addressed by a write keeps its value.
- R3: A read returns the OR, over readable fields at the address, of (value & field mask & access mask); bits outside the access mask or outside every field read as zero.
- R4: A read-only field (kind code 1) ignores bus writes; the write still returns status ok (code 2'b00).
- R5: Asserting load enable bit i for one cycle sets a read-only field i to (load value << lsb index of its mask) & mask at that clock edge; the load port has no effect on fields of any other kind.
- R6: A fixed field (kind code 2) keeps its reset value regardless of bus writes and loads.
- R7: A write-only field (kind code 3) takes bus writes, but a read of an address holding only write-only fields returns unmapped (code 2'b01) with read data zero.
- R8: An access to an address with no field for its direction returns unmapped (2'b01) and read data zero, and changes no field.
- R9: The value output for field i, bits [i*DW +: DW], equals (value & mask) shifted right by the index of the mask's least significant set bit.
- R10: The response is combinational in the cycle of the request; with no request the status is ok (2'b00) and read data is zero. Kind code 0 is read-write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access presented this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Word address |
| req_mask | input | DW | Per-bit access mask |
| req_wdata | input | DW | Write data, in word position |
| rsp_status | output | 2 | 2'b00 ok, 2'b01 unmapped |
| rsp_rdata | output | DW | Read data |
| ld_en | input | NF | Per-field internal load strobe |
| ld_val | input | NF*DW | Per-field right-aligned load values |
| fld_out | output | NF*DW | Per-field right-aligned current values |

## Verification
The bench builds the block with 32-bit words, 4-bit addresses and six fields: a read-write byte, a read-only byte and a fixed halfword sharing address 0, a read-write field at bit 4 and a single-bit read-write flag at bit 31 on address 1, and a write-only halfword alone at address 2, with address 3 left empty. This layout puts all three shared-word kinds under one access, exercises a nonzero shift on both the load and value paths, and reaches both unmapped cases: a read of a write-only-only address and any access to an empty address.

// File: rtl/mbf_pkg.sv
package mbf_pkg;

    typedef enum logic [1:0] {
        FK_RW    = 2'd0,
        FK_RO    = 2'd1,
        FK_FIXED = 2'd2,
        FK_WO    = 2'd3
    } field_kind_e;

    typedef enum logic [1:0] {
        ST_OK       = 2'b00,
        ST_UNMAPPED = 2'b01
    } bus_status_e;

    // Index of the lowest set bit; zero for an empty mask.
    function automatic int lsb_idx(input logic [63:0] m);
        int r;
        r = 0;
        for (int i = 63; i >= 0; i--) begin
            if (m[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/mbf_field.sv
module mbf_field
    import mbf_pkg::*;
#(
    parameter int              AW   = 4,
    parameter int              DW   = 32,
    parameter logic [AW-1:0]   ADDR = '0,
    parameter logic [DW-1:0]   MASK = '1,
    parameter field_kind_e     KIND = FK_RW,
    parameter logic [DW-1:0]   RST  = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_mask,
    input  logic [DW-1:0] acc_wdata,
    input  logic          ld_en,
    input  logic [DW-1:0] ld_val,
    output logic          rd_hit,
    output logic          wr_hit,
    output logic [DW-1:0] rd_part,
    output logic [DW-1:0] fld_val
);
    localparam int            SH       = lsb_idx(64'(MASK));
    localparam logic [DW-1:0] RST_IN   = RST & MASK;
    localparam bit            READABLE = (KIND != FK_WO);

    logic          addr_hit;
    logic [DW-1:0] eff_mask;
    logic [DW-1:0] val_q;
    logic [DW-1:0] val_nxt;

    assign addr_hit = acc_valid && (acc_addr == ADDR);
    assign rd_hit   = addr_hit && !acc_write && READABLE;
    assign wr_hit   = addr_hit && acc_write;
    assign eff_mask = acc_mask & MASK;

    always_comb begin
        val_nxt = val_q;
        unique case (KIND)
            FK_RW, FK_WO: begin
                if (wr_hit) val_nxt = (val_q & ~eff_mask) | (acc_wdata & eff_mask);
            end
            FK_RO: begin
                if (ld_en) val_nxt = (ld_val << SH) & MASK;
            end
            FK_FIXED: begin
                val_nxt = RST_IN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) val_q <= RST_IN;
        else        val_q <= val_nxt;
    end

    assign rd_part = rd_hit ? (val_q & eff_mask) : '0;
    assign fld_val = (val_q & MASK) >> SH;

endmodule

// File: rtl/mbf_rd_merge.sv
module mbf_rd_merge #(
    parameter int NF = 6,
    parameter int DW = 32
) (
    input  logic [NF*DW-1:0] rd_part_flat,
    input  logic [NF-1:0]    rd_hit,
    input  logic [NF-1:0]    wr_hit,
    output logic [DW-1:0]    rdata,
    output logic             any_rd,
    output logic             any_wr
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NF; i++) begin
            rdata = rdata | rd_part_flat[i*DW +: DW];
        end
    end

    assign any_rd = |rd_hit;
    assign any_wr = |wr_hit;

endmodule

// File: rtl/mbf_regbus.sv
module mbf_regbus
    import mbf_pkg::*;
#(
    parameter int                        AW = 4,
    parameter int                        DW = 32,
    parameter int                        NF = 6,
    parameter logic [NF-1:0][AW-1:0]     FLD_ADDR = {4'd2, 4'd1, 4'd1, 4'd0, 4'd0, 4'd0},
    parameter logic [NF-1:0][DW-1:0]     FLD_MASK = {32'h0000_FFFF, 32'h8000_0000, 32'h0000_0FF0,
                                                     32'hFFFF_0000, 32'h0000_FF00, 32'h0000_00FF},
    parameter logic [NF-1:0][1:0]        FLD_KIND = {2'd3, 2'd0, 2'd0, 2'd2, 2'd1, 2'd0},
    parameter logic [NF-1:0][DW-1:0]     FLD_RST  = {32'h0000_0000, 32'h8000_0000, 32'h0000_0000,
                                                     32'hCAFE_0000, 32'h0000_1200, 32'h0000_005A}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_mask,
    input  logic [DW-1:0]    req_wdata,
    output logic [1:0]       rsp_status,
    output logic [DW-1:0]    rsp_rdata,
    input  logic [NF-1:0]    ld_en,
    input  logic [NF*DW-1:0] ld_val,
    output logic [NF*DW-1:0] fld_out
);
    logic [NF*DW-1:0] rd_part_flat;
    logic [NF-1:0]    rd_hit;
    logic [NF-1:0]    wr_hit;
    logic             any_rd;
    logic             any_wr;
    logic [DW-1:0]    merged;

    for (genvar g = 0; g < NF; g++) begin : g_fld
        mbf_field #(
            .AW   (AW),
            .DW   (DW),
            .ADDR (FLD_ADDR[g]),
            .MASK (FLD_MASK[g]),
            .KIND (field_kind_e'(FLD_KIND[g])),
            .RST  (FLD_RST[g])
        ) u_fld (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc_valid (req_valid),
            .acc_write (req_write),
            .acc_addr  (req_addr),
            .acc_mask  (req_mask),
            .acc_wdata (req_wdata),
            .ld_en     (ld_en[g]),
            .ld_val    (ld_val[g*DW +: DW]),
            .rd_hit    (rd_hit[g]),
            .wr_hit    (wr_hit[g]),
            .rd_part   (rd_part_flat[g*DW +: DW]),
            .fld_val   (fld_out[g*DW +: DW])
        );
    end

    mbf_rd_merge #(.NF(NF), .DW(DW)) u_merge (
        .rd_part_flat (rd_part_flat),
        .rd_hit       (rd_hit),
        .wr_hit       (wr_hit),
        .rdata        (merged),
        .any_rd       (any_rd),
        .any_wr       (any_wr)
    );

    always_comb begin
        rsp_status = ST_OK;
        rsp_rdata  = '0;
        if (req_valid) begin
            if (req_write) begin
                rsp_status = any_wr ? ST_OK : ST_UNMAPPED;
            end else begin
                rsp_status = any_rd ? ST_OK : ST_UNMAPPED;
                rsp_rdata  = merged;
            end
        end
    end

endmodule

// File: rtl/mbf_regbus_chk.sv
module mbf_regbus_chk #(
    parameter int                    AW = 4,
    parameter int                    DW = 32,
    parameter int                    NF = 6,
    parameter logic [NF-1:0][AW-1:0] FLD_ADDR = '0,
    parameter logic [NF-1:0][1:0]    FLD_KIND = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [AW-1:0]    req_addr,
    input logic [1:0]       rsp_status,
    input logic [DW-1:0]    rsp_rdata,
    input logic [NF-1:0]    ld_en,
    input logic [NF*DW-1:0] fld_out,
    input logic [NF*DW-1:0] rd_part_flat
);
    logic overlap;

    always_comb begin
        overlap = 1'b0;
        for (int i = 0; i < NF; i++) begin
            for (int j = i + 1; j < NF; j++) begin
                if (|(rd_part_flat[i*DW +: DW] & rd_part_flat[j*DW +: DW])) overlap = 1'b1;
            end
        end
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !overlap); // R3

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_status == 2'b01) |-> (rsp_rdata == '0)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (rsp_status == 2'b00 && rsp_rdata == '0)); // R10

    for (genvar g = 0; g < NF; g++) begin : g_chk
        if (FLD_KIND[g] == 2'd2) begin : g_fixed
            AST_FIXED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
                $stable(fld_out[g*DW +: DW])); // R6
        end else if (FLD_KIND[g] == 2'd1) begin : g_ro
            AST_RO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !ld_en[g] |=> $stable(fld_out[g*DW +: DW])); // R4
        end else begin : g_rw
            AST_RW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !(req_valid && req_write && req_addr == FLD_ADDR[g])
                |=> $stable(fld_out[g*DW +: DW])); // R2
        end
    end

endmodule

bind mbf_regbus mbf_regbus_chk #(
    .AW       (AW),
    .DW       (DW),
    .NF       (NF),
    .FLD_ADDR (FLD_ADDR),
    .FLD_KIND (FLD_KIND)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .rsp_status   (rsp_status),
    .rsp_rdata    (rsp_rdata),
    .ld_en        (ld_en),
    .fld_out      (fld_out),
    .rd_part_flat (rd_part_flat)
);

// File: tb/mbf_regbus_tb.sv
module mbf_regbus_tb;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam int NF = 6;
    localparam logic [NF-1:0][AW-1:0] T_ADDR = {4'd2, 4'd1, 4'd1, 4'd0, 4'd0, 4'd0};
    localparam logic [NF-1:0][DW-1:0] T_MASK = {32'h0000_FFFF, 32'h8000_0000, 32'h0000_0FF0,
                                                32'hFFFF_0000, 32'h0000_FF00, 32'h0000_00FF};
    localparam logic [NF-1:0][1:0]    T_KIND = {2'd3, 2'd0, 2'd0, 2'd2, 2'd1, 2'd0};
    localparam logic [NF-1:0][DW-1:0] T_RST  = {32'h0000_0000, 32'h8000_0000, 32'h0000_0000,
                                                32'hCAFE_0000, 32'h0000_1200, 32'h0000_005A};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [AW-1:0]    req_addr = '0;
    logic [DW-1:0]    req_mask = '0;
    logic [DW-1:0]    req_wdata = '0;
    logic [1:0]       rsp_status;
    logic [DW-1:0]    rsp_rdata;
    logic [NF-1:0]    ld_en = '0;
    logic [NF*DW-1:0] ld_val = '0;
    logic [NF*DW-1:0] fld_out;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;

    typedef struct {
        logic [1:0]    st;
        logic [DW-1:0] rd;
        string         tag;
    } exp_t;
    exp_t sb[$];

    logic [DW-1:0] mdl [NF];

    always #2 clk = ~clk;

    mbf_regbus #(
        .AW(AW), .DW(DW), .NF(NF),
        .FLD_ADDR(T_ADDR), .FLD_MASK(T_MASK), .FLD_KIND(T_KIND), .FLD_RST(T_RST)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_mask(req_mask), .req_wdata(req_wdata),
        .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
        .ld_en(ld_en), .ld_val(ld_val), .fld_out(fld_out)
    );

    function automatic int low_bit(input logic [DW-1:0] m);
        for (int i = 0; i < DW; i++) if (m[i]) return i;
        return 0;
    endfunction

    function automatic logic [DW-1:0] fld_exp(input int i);
        return (mdl[i] & T_MASK[i]) >> low_bit(T_MASK[i]);
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] m,
                          input logic [DW-1:0] d, input string tag);
        exp_t e;
        bit hit_wr, hit_rd;
        logic [DW-1:0] rd;
        @(negedge clk);
        ld_en = '0;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_mask = m; req_wdata = d;
        hit_wr = 0; hit_rd = 0; rd = '0;
        for (int i = 0; i < NF; i++) begin
            if (T_ADDR[i] == a) begin
                hit_wr = 1;
                if (T_KIND[i] != 2'd3) begin
                    hit_rd = 1;
                    rd = rd | (mdl[i] & T_MASK[i] & m);
                end
            end
        end
        e.tag = tag;
        if (wr) begin
            e.st = hit_wr ? 2'b00 : 2'b01;
            e.rd = '0;
            for (int i = 0; i < NF; i++) begin
                if (T_ADDR[i] == a && (T_KIND[i] == 2'd0 || T_KIND[i] == 2'd3))
                    mdl[i] = (mdl[i] & ~(m & T_MASK[i])) | (d & m & T_MASK[i]);
            end
        end else begin
            e.st = hit_rd ? 2'b00 : 2'b01;
            e.rd = hit_rd ? rd : '0;
        end
        sb.push_back(e);
    endtask

    task automatic load(input int i, input logic [DW-1:0] v);
        @(negedge clk);
        req_valid = 1'b0;
        ld_en = '0;
        ld_en[i] = 1'b1;
        ld_val[i*DW +: DW] = v;
        if (T_KIND[i] == 2'd1) mdl[i] = (v << low_bit(T_MASK[i])) & T_MASK[i];
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        ld_en = '0;
    endtask

    task automatic check_fields(input string tag);
        for (int i = 0; i < NF; i++) check(tag, fld_out[i*DW +: DW], fld_exp(i));
    endtask

    // Monitor: pops the scoreboard for every presented request.
    always @(negedge clk) begin
        #1;
        if (rst_n && req_valid) begin
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL monitor: actual=response expected=no pending item");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " status"}, DW'(rsp_status), DW'(e.st));
                check({e.tag, " rdata"}, rsp_rdata, e.rd);
            end
        end
    end

    initial begin
        for (int i = 0; i < NF; i++) mdl[i] = T_RST[i] & T_MASK[i];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check_fields("R1 R9 reset field outputs");

        access(0, 4'd0, 32'hFFFF_FFFF, 32'h0, "R1 R3 reset word");
        access(1, 4'd0, 32'hFFFF_FFFF, 32'h1122_3344, "R2 R4 R6 full write shared word");
        access(0, 4'd0, 32'hFFFF_FFFF, 32'h0, "R2 R4 R6 readback");
        access(1, 4'd0, 32'h0000_000F, 32'hFFFF_FFF0, "R2 nibble merge");
        access(0, 4'd0, 32'h00FF_00F0, 32'h0, "R3 partial read mask");
        access(1, 4'd1, 32'h8000_00F0, 32'h0000_0AB0, "R2 two fields one write");
        access(0, 4'd1, 32'hFFFF_FFFF, 32'h0, "R2 R3 addr1 readback");
        access(0, 4'd2, 32'hFFFF_FFFF, 32'h0, "R7 read write-only word");
        access(1, 4'd2, 32'h0000_FFFF, 32'h1234_ABCD, "R7 write write-only word");
        access(1, 4'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8 write empty addr");
        access(0, 4'd3, 32'hFFFF_FFFF, 32'h0, "R8 read empty addr");
        access(0, 4'd0, 32'hFFFF_FFFF, 32'h0, "R8 no side effect");
        idle(); #1;
        check("R10 idle status", DW'(rsp_status), 32'h0);
        check("R10 idle rdata", rsp_rdata, 32'h0);
        check_fields("R7 R9 field outputs after writes");

        load(1, 32'h0000_007E);
        load(2, 32'h0000_1111);
        load(0, 32'h0000_00FF);
        access(0, 4'd0, 32'hFFFF_FFFF, 32'h0, "R5 R6 read after loads");
        idle(); #1;
        check_fields("R5 R6 R9 field outputs after loads");
        check("R5 sb drained", DW'(sb.size()), 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule